// File: doc/BRIEF.md
# SM3 Dual-Round Compression Unit

This block runs two successive rounds of the SM3 hash compression function. One 128-bit operand carries the working words A, B, E and F. A second 128-bit operand carries C, D, G and H, which arrive un-rotated from the previous step. A third operand carries the message words W0, W1, W4 and W5. An 8-bit round selector picks the even round at which the pair starts. The block returns the updated A, B, E and F packed into one 128-bit word. Message expansion, the chaining XOR and the bookkeeping of C, D, G and H all happen outside the block.

A parameter chooses the build. The two-cycle build runs one round per clock, holds a stage register between the rounds, and accepts a new request only while idle. The single-cycle build chains both rounds between the input and the result register, and it can accept a request on every clock. In both builds a one-cycle `done` pulse marks a fresh result. The result stays on `result` until the next one is written.

Top module: `sm3_dual_round`

## Requirements
- R1: `result[127:96]` holds A, `result[95:64]` holds B, `result[63:32]` holds E and `result[31:0]` holds F, all after the second round. On the inputs, `st_abef` carries A, B, E, F and `st_cdgh` carries C, D, G, H, each from bit 127 down, and `msg` carries W0, W1, W4, W5 from bit 0 up.
- R2: Before the first round, C and D are rotated left by 9, and G and H are rotated left by 19.
- R3: The effective round is `rnd_sel & 0x3E`. Bit 0 and bits 7:6 of `rnd_sel` have no effect on the result.
- R4: The round constant base is 0x79CC4519 for effective rounds below 16 and 0x7A879D8A otherwise. The base is rotated left by the effective round for the first round, and by one place more for the second round.
- R5: For effective rounds below 16, both boolean functions are the three-way XOR. Otherwise the A-side function is the majority and the E-side function is the choice (x&y)|(~x&z). The same selection applies to both rounds.
- R6: Each round computes S1 = rol(rol(A,12)+E+K, 7), S2 = S1 ^ rol(A,12), T1 = FA(A,B,C)+D+S2+(Wi^Wi+4) and T2 = FE(E,F,G)+H+S1+Wi, all sums modulo 2^32. The first round uses W0 and W4, the second uses W1 and W5.
- R7: After each round, the new A is T1, the new B is the old A, the new C is rol(old B,9) and the new D is the old C. The new E is T2^rol(T2,9)^rol(T2,17), the new F is the old E, the new G is rol(old F,19) and the new H is the old G.
- R8: A request is accepted when `start` is high while `idle` is high. `done` rises for exactly one cycle, 2 cycles after acceptance in the two-cycle build and 1 cycle after it in the single-cycle build. `result` is valid while `done` is high and does not change while `done` is low.
- R9: In the two-cycle build, `idle` is low for the cycle after an accepted request. A `start` during that cycle is ignored: it produces no `done` and does not alter the pending result.
- R10: After reset, `done` is 0, `result` is 0 and `idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| rnd_sel | input | RND_W (8) | Round selector, masked to an even value 0..62 |
| st_cdgh | input | 128 | C, D, G, H state words, un-rotated |
| st_abef | input | 128 | A, B, E, F state words |
| msg | input | 128 | Message words W0, W1, W4, W5 |
| idle | output | 1 | High when a request can be accepted |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 128 | Updated A, B, E, F after two rounds |

## Verification
The two-cycle build and the single-cycle build are driven side by side from the same stimulus. Inputs change on the falling edge. If `start` is seen at rising edge k, the single-cycle result and `done` are sampled at the falling edge after edge k. The two-cycle build is sampled at the next falling edge, after edge k+1, and its `done` and `idle` are also checked at the earlier falling edge, where they must show the pending state. One falling edge later the pulse is checked as gone and the result as held, so every sample falls half a period after the register that drives it.

// File: rtl/sm3_rnd_pkg.sv
package sm3_rnd_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int VEC_W  = WORD_W * LANES;
  localparam int RNUM_W = 6;
  localparam logic [RNUM_W-1:0] RND_MASK = 6'h3E;
  localparam int LATE_START = 16;
  localparam logic [WORD_W-1:0] K_EARLY = 32'h79CC4519;
  localparam logic [WORD_W-1:0] K_LATE  = 32'h7A879D8A;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a, b, c, d, e, f, g, h;
  } sm3_st_t;

  typedef struct packed {
    sm3_st_t st;
    word_t   w_lo;
    word_t   w_hi;
    word_t   k;
    logic    late;
  } sm3_stage_t;

  function automatic word_t rol32(input word_t x, input int unsigned n);
    logic [2*WORD_W-1:0] t;
    t = {x, x} << (n % WORD_W);
    return t[2*WORD_W-1:WORD_W];
  endfunction

  function automatic word_t p0_mix(input word_t x);
    return x ^ rol32(x, 9) ^ rol32(x, 17);
  endfunction

  function automatic word_t fn_a(input word_t x, input word_t y, input word_t z, input logic late);
    return late ? ((x & y) | (x & z) | (y & z)) : (x ^ y ^ z);
  endfunction

  function automatic word_t fn_e(input word_t x, input word_t y, input word_t z, input logic late);
    return late ? ((x & y) | (~x & z)) : (x ^ y ^ z);
  endfunction
endpackage

// File: rtl/sm3_in_prep.sv
module sm3_in_prep
  import sm3_rnd_pkg::*;
(
  input  logic [VEC_W-1:0] cdgh,
  input  logic [VEC_W-1:0] abef,
  output sm3_st_t          st
);
  word_t lane_x [LANES];
  word_t lane_y [LANES];

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign lane_x[gi] = abef[gi*WORD_W +: WORD_W];
      assign lane_y[gi] = cdgh[gi*WORD_W +: WORD_W];
    end
  endgenerate

  always_comb begin
    st.a = lane_x[3];
    st.b = lane_x[2];
    st.e = lane_x[1];
    st.f = lane_x[0];
    st.c = rol32(lane_y[3], 9);
    st.d = rol32(lane_y[2], 9);
    st.g = rol32(lane_y[1], 19);
    st.h = rol32(lane_y[0], 19);
  end
endmodule

// File: rtl/sm3_const_gen.sv
module sm3_const_gen
  import sm3_rnd_pkg::*;
(
  input  logic [RNUM_W-1:0] round,
  output word_t             k_first,
  output word_t             k_second,
  output logic              late
);
  word_t base;

  always_comb begin
    late     = (int'(round) >= LATE_START);
    base     = late ? K_LATE : K_EARLY;
    k_first  = rol32(base, int'(round));
    k_second = rol32(k_first, 1);
  end
endmodule

// File: rtl/sm3_round_step.sv
module sm3_round_step
  import sm3_rnd_pkg::*;
(
  input  sm3_stage_t cur,
  output sm3_st_t    nxt
);
  word_t a_r12, s1, s2, t1, t2;

  always_comb begin
    a_r12 = rol32(cur.st.a, 12);
    s1    = rol32(a_r12 + cur.st.e + cur.k, 7);
    s2    = s1 ^ a_r12;
    t1    = fn_a(cur.st.a, cur.st.b, cur.st.c, cur.late) + cur.st.d + s2 + (cur.w_lo ^ cur.w_hi);
    t2    = fn_e(cur.st.e, cur.st.f, cur.st.g, cur.late) + cur.st.h + s1 + cur.w_lo;

    nxt.a = t1;
    nxt.b = cur.st.a;
    nxt.c = rol32(cur.st.b, 9);
    nxt.d = cur.st.c;
    nxt.e = p0_mix(t2);
    nxt.f = cur.st.e;
    nxt.g = rol32(cur.st.f, 19);
    nxt.h = cur.st.g;
  end
endmodule

// File: rtl/sm3_dual_round.sv
module sm3_dual_round
  import sm3_rnd_pkg::*;
#(
  parameter bit TWO_CYCLE = 1'b1,
  parameter int RND_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RND_W-1:0] rnd_sel,
  input  logic [VEC_W-1:0] st_cdgh,
  input  logic [VEC_W-1:0] st_abef,
  input  logic [VEC_W-1:0] msg,
  output logic             idle,
  output logic             done,
  output logic [VEC_W-1:0] result
);
  logic              accept;
  logic              busy;
  logic              fin_en;
  logic [RNUM_W-1:0] round_eff;
  word_t             k0, k1;
  logic              late;
  sm3_st_t           st0, st1, st2;
  sm3_stage_t        stg0, stg1_d, stg1;

  // events brought out for the checker
  word_t evt_b, evt_d, evt_f, evt_h;
  word_t evt_in_a, evt_in_c, evt_in_e, evt_in_g;

  assign round_eff = rnd_sel[RNUM_W-1:0] & RND_MASK;
  assign idle      = !busy;
  assign accept    = start && !busy;

  sm3_in_prep u_prep (
    .cdgh (st_cdgh),
    .abef (st_abef),
    .st   (st0)
  );

  sm3_const_gen u_kgen (
    .round    (round_eff),
    .k_first  (k0),
    .k_second (k1),
    .late     (late)
  );

  always_comb begin
    stg0.st   = st0;
    stg0.w_lo = msg[0*WORD_W +: WORD_W];
    stg0.w_hi = msg[2*WORD_W +: WORD_W];
    stg0.k    = k0;
    stg0.late = late;
  end

  sm3_round_step u_rnd0 (
    .cur (stg0),
    .nxt (st1)
  );

  always_comb begin
    stg1_d.st   = st1;
    stg1_d.w_lo = msg[1*WORD_W +: WORD_W];
    stg1_d.w_hi = msg[3*WORD_W +: WORD_W];
    stg1_d.k    = k1;
    stg1_d.late = late;
  end

  generate
    if (TWO_CYCLE) begin : g_staged
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg1 <= '0;
          busy <= 1'b0;
        end else begin
          busy <= accept;
          if (accept) stg1 <= stg1_d;
        end
      end
      assign fin_en = busy;
    end else begin : g_flat
      assign stg1   = stg1_d;
      assign busy   = 1'b0;
      assign fin_en = accept;
    end
  endgenerate

  sm3_round_step u_rnd1 (
    .cur (stg1),
    .nxt (st2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= fin_en;
      if (fin_en) result <= {st2.a, st2.b, st2.e, st2.f};
    end
  end

  assign evt_b    = stg1.st.b;
  assign evt_d    = stg1.st.d;
  assign evt_f    = stg1.st.f;
  assign evt_h    = stg1.st.h;
  assign evt_in_a = st_abef[3*WORD_W +: WORD_W];
  assign evt_in_e = st_abef[1*WORD_W +: WORD_W];
  assign evt_in_c = st_cdgh[3*WORD_W +: WORD_W];
  assign evt_in_g = st_cdgh[1*WORD_W +: WORD_W];
endmodule

// File: rtl/sm3_dual_round_chk.sv
module sm3_dual_round_chk
  import sm3_rnd_pkg::*;
#(
  parameter bit TWO_CYCLE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle,
  input logic             done,
  input logic [VEC_W-1:0] result,
  input logic             accept,
  input logic             busy,
  input word_t            evt_b,
  input word_t            evt_d,
  input word_t            evt_f,
  input word_t            evt_h,
  input word_t            evt_in_a,
  input word_t            evt_in_c,
  input word_t            evt_in_e,
  input word_t            evt_in_g
);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  generate
    if (TWO_CYCLE) begin : g_two
      // R8
      done_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(accept, 2));
      // R9
      busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);
      // R9
      idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !idle);
      // R7
      chain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (evt_b == $past(evt_in_a)) && (evt_f == $past(evt_in_e)));
      // R2
      prerot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (evt_d == rol32($past(evt_in_c), 9)) && (evt_h == rol32($past(evt_in_g), 19)));
    end else begin : g_one
      // R8
      done_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(accept));
      // R9
      always_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle && !busy);
    end
  endgenerate
endmodule

bind sm3_dual_round sm3_dual_round_chk #(.TWO_CYCLE(TWO_CYCLE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .idle     (idle),
  .done     (done),
  .result   (result),
  .accept   (accept),
  .busy     (busy),
  .evt_b    (evt_b),
  .evt_d    (evt_d),
  .evt_f    (evt_f),
  .evt_h    (evt_h),
  .evt_in_a (evt_in_a),
  .evt_in_c (evt_in_c),
  .evt_in_e (evt_in_e),
  .evt_in_g (evt_in_g)
);

// File: tb/sm3_dual_round_tb_top.sv
module sm3_dual_round_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [7:0]   rnd_sel = '0;
  logic [127:0] st_cdgh = '0, st_abef = '0, msg = '0;
  logic         idle_s, done_s, idle_f, done_f;
  logic [127:0] res_s, res_f;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  sm3_dual_round #(.TWO_CYCLE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rnd_sel(rnd_sel),
    .st_cdgh(st_cdgh), .st_abef(st_abef), .msg(msg),
    .idle(idle_s), .done(done_s), .result(res_s)
  );

  sm3_dual_round #(.TWO_CYCLE(1'b0)) dut_fast_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rnd_sel(rnd_sel),
    .st_cdgh(st_cdgh), .st_abef(st_abef), .msg(msg),
    .idle(idle_f), .done(done_f), .result(res_f)
  );

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    int m = n % 32;
    if (m == 0) return v;
    return (v << m) | (v >> (32 - m));
  endfunction

  // Independent restatement of the two rounds from the requirements
  function automatic logic [127:0] golden(input logic [127:0] cdgh, input logic [127:0] abef,
                                          input logic [127:0] m, input logic [7:0] sel);
    int r = int'(sel & 8'h3E);
    logic [31:0] va, vb, vc, vd, ve, vf, vg, vh, kk, ss1, ss2, tt1, tt2, fa, fe, wl, wh;
    va = abef[127:96]; vb = abef[95:64]; ve = abef[63:32]; vf = abef[31:0];
    vc = rl(cdgh[127:96], 9);  vd = rl(cdgh[95:64], 9);
    vg = rl(cdgh[63:32], 19);  vh = rl(cdgh[31:0], 19);
    kk = rl((r < 16) ? 32'h79CC4519 : 32'h7A879D8A, r);
    for (int i = 0; i < 2; i++) begin
      wl = (i == 0) ? m[31:0] : m[63:32];
      wh = (i == 0) ? m[95:64] : m[127:96];
      if (r < 16) begin
        fa = va ^ vb ^ vc;
        fe = ve ^ vf ^ vg;
      end else begin
        fa = (va & vb) | (vb & vc) | (va & vc);
        fe = (ve & vf) | (~ve & vg);
      end
      ss1 = rl(rl(va, 12) + ve + kk, 7);
      ss2 = ss1 ^ rl(va, 12);
      tt1 = fa + vd + ss2 + (wl ^ wh);
      tt2 = fe + vh + ss1 + wl;
      vd = vc; vc = rl(vb, 9); vb = va; va = tt1;
      vh = vg; vg = rl(vf, 19); vf = ve; ve = tt2 ^ rl(tt2, 9) ^ rl(tt2, 17);
      kk = rl(kk, 1);
    end
    return {va, vb, ve, vf};
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rand_vec(output logic [127:0] v);
    for (int i = 0; i < 4; i++) begin
      seed = next_rand(seed);
      v[i*32 +: 32] = seed;
    end
  endtask

  // one request through both builds; checks latency, pulse and value
  task automatic run_op(input string req, input logic [127:0] c_in, input logic [127:0] a_in,
                        input logic [127:0] m_in, input logic [7:0] sel, input logic [127:0] exp);
    @(negedge clk);
    st_cdgh = c_in; st_abef = a_in; msg = m_in; rnd_sel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " R8 fast done"}, 128'(done_f), 128'(1));
    chk({req, " fast result"}, res_f, exp);
    chk({req, " R8 slow done early"}, 128'(done_s), 128'(0));
    chk({req, " R9 slow idle low"}, 128'(idle_s), 128'(0));
    @(negedge clk);
    chk({req, " R8 slow done"}, 128'(done_s), 128'(1));
    chk({req, " slow result"}, res_s, exp);
    chk({req, " R8 fast pulse end"}, 128'(done_f), 128'(0));
    @(negedge clk);
    chk({req, " R8 slow pulse end"}, 128'(done_s), 128'(0));
    chk({req, " R8 slow hold"}, res_s, exp);
  endtask

  task automatic t_reset();
    chk("R10 done_s", 128'(done_s), 128'(0));
    chk("R10 result_s", res_s, 128'(0));
    chk("R10 idle_s", 128'(idle_s), 128'(1));
    chk("R10 done_f", 128'(done_f), 128'(0));
    chk("R10 result_f", res_f, 128'(0));
  endtask

  task automatic t_lanes();
    logic [127:0] c = 128'h44444444_33333333_22222222_11111111;
    logic [127:0] a = 128'h88888888_77777777_66666666_55555555;
    logic [127:0] m = 128'hdddddddd_cccccccc_bbbbbbbb_aaaaaaaa;
    run_op("R1 R2 lanes", c, a, m, 8'd0, golden(c, a, m, 8'd0));
  endtask

  task automatic t_early();
    logic [127:0] c, a, m;
    int rl_list[3] = '{0, 2, 14};
    foreach (rl_list[i]) begin
      rand_vec(c); rand_vec(a); rand_vec(m);
      run_op("R4 R5 R6 R7 early", c, a, m, 8'(rl_list[i]), golden(c, a, m, 8'(rl_list[i])));
    end
  endtask

  task automatic t_late();
    logic [127:0] c, a, m;
    int rl_list[3] = '{16, 30, 62};
    foreach (rl_list[i]) begin
      rand_vec(c); rand_vec(a); rand_vec(m);
      run_op("R4 R5 R6 R7 late", c, a, m, 8'(rl_list[i]), golden(c, a, m, 8'(rl_list[i])));
    end
  endtask

  task automatic t_wrap();
    logic [127:0] ones = '1;
    run_op("R6 wrap", ones, ones, ones, 8'd20, golden(ones, ones, ones, 8'd20));
  endtask

  task automatic t_mask();
    logic [127:0] c, a, m;
    rand_vec(c); rand_vec(a); rand_vec(m);
    // bits 7:6 and bit 0 set on top of round 16: same as plain 16
    run_op("R3 mask 16", c, a, m, 8'hD1, golden(c, a, m, 8'd16));
    // 0x4F masks to 14: early constant and XOR functions
    run_op("R3 mask 14", c, a, m, 8'h4F, golden(c, a, m, 8'd14));
  endtask

  task automatic t_busy();
    logic [127:0] c1, a1, m1, c2, a2, m2, e1, e2;
    rand_vec(c1); rand_vec(a1); rand_vec(m1);
    rand_vec(c2); rand_vec(a2); rand_vec(m2);
    e1 = golden(c1, a1, m1, 8'd6);
    e2 = golden(c2, a2, m2, 8'd40);
    @(negedge clk);
    st_cdgh = c1; st_abef = a1; msg = m1; rnd_sel = 8'd6; start = 1'b1;
    @(negedge clk);
    st_cdgh = c2; st_abef = a2; msg = m2; rnd_sel = 8'd40;
    chk("R9 slow idle low", 128'(idle_s), 128'(0));
    @(negedge clk);
    start = 1'b0;
    chk("R9 slow keeps first", res_s, e1);
    chk("R9 slow done", 128'(done_s), 128'(1));
    chk("R8 fast back-to-back", res_f, e2);
    @(negedge clk);
    chk("R9 no extra done", 128'(done_s), 128'(0));
    chk("R9 result unchanged", res_s, e1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_lanes();
    t_early();
    t_late();
    t_wrap();
    t_mask();
    t_busy();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog R8: actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule